// File: doc/BRIEF.md
# Fractional MAC with guard bits

This block is a multiply-accumulate datapath for signed fractional arithmetic. Two 24-bit two's-complement fractions, each in the range -1.0 up to but not including +1.0 with the binary point just right of the sign bit, are multiplied. The product is aligned so that its binary point matches the accumulator's high word. It is then cleared into, loaded into, or added to a 56-bit accumulator. That accumulator is made of an 8-bit guard extension, a 24-bit high word and a 24-bit low word.

A typical filter loop first issues a clear. It then streams coefficient and sample pairs with the accumulate command, one per cycle. The guard bits let the running sum leave the ±1.0 range for a while without losing information. The caller reads either the full accumulator or a 24-bit result taken from the high word. That result is clamped to the largest positive or most negative fraction whenever the guard bits show an overflow.

Top module: `frac_mac`

## Requirements
- R1: While and after reset, before any sample is accepted, `acc_out` is zero, `out_valid` is 0, `ovf` is 0 and `sat_out` is zero.
- R2: A sample presented with `in_valid` high at clock edge N updates the accumulator at edge N+1. `out_valid` is high for exactly the cycle after edge N+1 for each accepted sample, whatever its mode.
- R3: Mode 2'b00 (clear) sets the accumulator to zero regardless of the operands.
- R4: Mode 2'b01 (load) sets the accumulator to the product 2·a·b, with 48 fractional-aligned bits in bits 47:0, sign-extended through guard bits 55:48.
- R5: Mode 2'b10 (accumulate) adds the sign-extended aligned product to the accumulator, modulo 2^56.
- R6: Mode 2'b11 is reserved and leaves the accumulator unchanged, and cycles with `in_valid` low leave it unchanged too.
- R7: The product of -1.0 (0x800000) by -1.0 is clamped to the largest positive 48-bit fraction 0x7FFFFFFFFFFF.
- R8: `ovf` is high exactly when accumulator bits 55 down to 47 are not all equal.
- R9: `sat_out` equals accumulator bits 47:24 when `ovf` is low. When `ovf` is high it is 0x7FFFFF if bit 55 is 0 and 0x800000 if bit 55 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair and mode are accepted on this edge |
| mode | input | 2 | 00 clear, 01 load, 10 accumulate, 11 reserved (hold) |
| op_a | input | 24 | First fractional operand |
| op_b | input | 24 | Second fractional operand |
| acc_out | output | 56 | Full accumulator: guard, high word, low word |
| out_valid | output | 1 | Accumulator reflects a newly accepted sample |
| ovf | output | 1 | Sum has left the range the high word can hold |
| sat_out | output | 24 | High word, clamped on overflow |

## Verification
A wrong accumulator value persists until the next clear or load, so any mistake in the product alignment, sign extension or the -1 × -1 clamp appears on `acc_out` one cycle after the accepted sample. It stays visible on every later cycle. A wrong guard-bit comparison shows on `ovf` and `sat_out` in the same cycle the accumulator crosses the range. The corner cases exercised are full-scale negative products, sums that cross the positive and negative limits, reserved-mode holds, and streams of back-to-back samples under a cycle-by-cycle model.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  typedef enum logic [1:0] {
    MODE_CLR  = 2'b00,
    MODE_LOAD = 2'b01,
    MODE_ACC  = 2'b10,
    MODE_NOP  = 2'b11
  } mac_mode_e;

endpackage

// File: rtl/frac_mult.sv
module frac_mult #(
  parameter int OP_W = 24,
  localparam int PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic [PW-1:0]   prod
);

  localparam logic [OP_W-1:0] NEG_ONE = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PW-1:0]   POS_MAX = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic                 both_neg_one;

  // full signed product, then shift out the duplicated sign bit
  assign raw          = PW'($signed(a)) * PW'($signed(b));
  assign both_neg_one = (a == NEG_ONE) && (b == NEG_ONE);
  assign prod         = both_neg_one ? POS_MAX : {raw[PW-2:0], 1'b0};

  AST_SAME_SIGN_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (a[OP_W-1] == b[OP_W-1]) |-> !prod[PW-1]);  // R7

endmodule

// File: rtl/frac_acc_core.sv
module frac_acc_core
  import frac_mac_pkg::*;
#(
  parameter int OP_W    = 24,
  parameter int GUARD_W = 8,
  localparam int PW     = 2 * OP_W,
  localparam int ACC_W  = GUARD_W + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  mac_mode_e        mode,
  input  logic [PW-1:0]    prod,
  output logic [ACC_W-1:0] acc,
  output logic             acc_vld
);

  logic [ACC_W-1:0] acc_q, acc_nxt, prod_ext;
  logic             vld_q;

  assign prod_ext = {{GUARD_W{prod[PW-1]}}, prod};

  always_comb begin
    acc_nxt = acc_q;
    if (vld) begin
      case (mode)
        MODE_CLR:  acc_nxt = '0;
        MODE_LOAD: acc_nxt = prod_ext;
        MODE_ACC:  acc_nxt = acc_q + prod_ext;
        default:   acc_nxt = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      vld_q <= vld;
    end
  end

  assign acc     = acc_q;
  assign acc_vld = vld_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && mode == MODE_CLR) |=> (acc == '0));  // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld || mode == MODE_NOP) |=> $stable(acc));  // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> acc_vld);  // R2

endmodule

// File: rtl/frac_out_sat.sv
module frac_out_sat #(
  parameter int OP_W    = 24,
  parameter int GUARD_W = 8,
  localparam int ACC_W  = GUARD_W + 2 * OP_W,
  localparam int HI_LSB = OP_W,
  localparam int TOP_N  = GUARD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc,
  output logic             ovf,
  output logic [OP_W-1:0]  sat
);

  localparam logic [OP_W-1:0] SAT_POS = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] SAT_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic [TOP_N-1:0] top_bits;

  assign top_bits = acc[ACC_W-1 -: TOP_N];
  assign ovf      = !((top_bits == '0) || (top_bits == '1));

  always_comb begin
    if (!ovf)               sat = acc[HI_LSB +: OP_W];
    else if (acc[ACC_W-1])  sat = SAT_NEG;
    else                    sat = SAT_POS;
  end

  AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (sat == SAT_POS || sat == SAT_NEG));  // R9
  AST_SIGN_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    sat[OP_W-1] == acc[ACC_W-1]);  // R8

endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int OP_W    = 24,
  parameter int GUARD_W = 8,
  localparam int PW     = 2 * OP_W,
  localparam int ACC_W  = GUARD_W + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_out,
  output logic             out_valid,
  output logic             ovf,
  output logic [OP_W-1:0]  sat_out
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // operand capture stage
  logic [OP_W-1:0] a_q, a_nxt, b_q, b_nxt;
  mac_mode_e       mode_q, mode_nxt;
  logic            vld_q;
  logic [PW-1:0]   prod;

  always_comb begin
    a_nxt    = a_q;
    b_nxt    = b_q;
    mode_nxt = mode_q;
    if (in_valid) begin
      a_nxt    = op_a;
      b_nxt    = op_b;
      mode_nxt = mac_mode_e'(mode);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= MODE_NOP;
      vld_q  <= 1'b0;
    end else begin
      a_q    <= a_nxt;
      b_q    <= b_nxt;
      mode_q <= mode_nxt;
      vld_q  <= in_valid;
    end
  end

  frac_mult #(.OP_W(OP_W)) u_mult (
    .clk  (clk),
    .rst_n(rst_s_n),
    .a    (a_q),
    .b    (b_q),
    .prod (prod)
  );

  frac_acc_core #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .vld    (vld_q),
    .mode   (mode_q),
    .prod   (prod),
    .acc    (acc_out),
    .acc_vld(out_valid)
  );

  frac_out_sat #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_sat (
    .clk  (clk),
    .rst_n(rst_s_n),
    .acc  (acc_out),
    .ovf  (ovf),
    .sat  (sat_out)
  );

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> ##1 out_valid);  // R2
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_s_n |=> (acc_out == '0 && !out_valid));  // R1

endmodule

// File: tb/frac_mac_test.sv
module frac_mac_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic [23:0] op_a, op_b;
  logic [55:0] acc_out;
  logic        out_valid, ovf;
  logic [23:0] sat_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frac_mac uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid),
    .ovf(ovf), .sat_out(sat_out)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { bit v; bit [1:0] m; bit [23:0] a; bit [23:0] b; } stim_t;
  stim_t       pend[$];
  logic [55:0] m_acc = '0;
  bit          m_vld = 0;

  function automatic logic [55:0] aligned_prod(bit [23:0] a, bit [23:0] b);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb * 2;
    if (p == (longint'(1) <<< 47)) p = (longint'(1) <<< 47) - 1;  // R7
    return p[55:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend.delete();
      m_acc = '0;
      m_vld = 0;
    end else begin
      stim_t s, e;
      s.v = in_valid; s.m = mode; s.a = op_a; s.b = op_b;
      pend.push_back(s);
      m_vld = 0;
      if (pend.size() > 1) begin
        e = pend.pop_front();
        m_vld = e.v;
        if (e.v) begin
          case (e.m)
            2'b00: m_acc = '0;
            2'b01: m_acc = aligned_prod(e.a, e.b);
            2'b10: m_acc = m_acc + aligned_prod(e.a, e.b);
            default: ;
          endcase
        end
      end
    end
  end

  function automatic bit exp_ovf(logic [55:0] x);
    return !((x[55:47] == 9'h000) || (x[55:47] == 9'h1FF));
  endfunction

  function automatic logic [23:0] exp_sat(logic [55:0] x);
    if (!exp_ovf(x)) return x[47:24];
    return x[55] ? 24'h800000 : 24'h7FFFFF;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 acc_out vs model", 64'(acc_out), 64'(m_acc));
      chk("R2 out_valid vs model", 64'(out_valid), 64'(m_vld));
      chk("R8 ovf vs model", 64'(ovf), 64'(exp_ovf(m_acc)));
      chk("R9 sat_out vs model", 64'(sat_out), 64'(exp_sat(m_acc)));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic issue(bit [1:0] m, bit [23:0] a, bit [23:0] b);
    @(negedge clk);
    in_valid = 1; mode = m; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 0; mode = 2'b11; op_a = '0; op_b = '0;
    chk("R2 no early out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R2 out_valid after one stage", 64'(out_valid), 64'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; mode = 2'b11; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 acc in reset", 64'(acc_out), 64'd0);
    chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 acc after reset", 64'(acc_out), 64'd0);
    chk("R1 ovf after reset", 64'(ovf), 64'd0);
    chk("R1 sat after reset", 64'(sat_out), 64'd0);

    // R4: 0.5 * 0.5 = 0.25
    issue(2'b01, 24'h400000, 24'h400000);
    chk("R4 load 0.25", 64'(acc_out), 64'h00_200000_000000);
    chk("R9 sat 0.25", 64'(sat_out), 64'h200000);

    // R6: reserved mode and idle cycles hold
    issue(2'b11, 24'h7FFFFF, 24'h7FFFFF);
    repeat (3) @(negedge clk);
    chk("R6 reserved mode holds", 64'(acc_out), 64'h00_200000_000000);

    // R3: clear ignores operands
    issue(2'b00, 24'h123456, 24'h654321);
    chk("R3 clear", 64'(acc_out), 64'd0);

    // R7: -1 * -1 clamped
    issue(2'b01, 24'h800000, 24'h800000);
    chk("R7 neg one squared", 64'(acc_out), 64'h00_7FFFFF_FFFFFF);
    chk("R8 no ovf at max", 64'(ovf), 64'd0);
    chk("R9 sat at max", 64'(sat_out), 64'h7FFFFF);

    // R5/R8/R9: positive overflow into guard bits
    issue(2'b10, 24'h800000, 24'h800000);
    chk("R5 accumulate past +1", 64'(acc_out), 64'h00_FFFFFF_FFFFFE);
    chk("R8 ovf positive", 64'(ovf), 64'd1);
    chk("R9 sat positive clamp", 64'(sat_out), 64'h7FFFFF);

    // negative side: -0.5 loaded then summed four times total
    issue(2'b01, 24'h800000, 24'h400000);
    chk("R4 load -0.5 sign extended", 64'(acc_out), 64'hFF_C00000_000000);
    chk("R8 no ovf at -0.5", 64'(ovf), 64'd0);
    issue(2'b10, 24'h800000, 24'h400000);
    chk("R5 reach -1.0", 64'(acc_out), 64'hFF_800000_000000);
    chk("R8 no ovf at -1.0", 64'(ovf), 64'd0);
    issue(2'b10, 24'h800000, 24'h400000);
    issue(2'b10, 24'h800000, 24'h400000);
    chk("R5 accumulate to -2.0", 64'(acc_out), 64'hFF_000000_000000);
    chk("R8 ovf negative", 64'(ovf), 64'd1);
    chk("R9 sat negative clamp", 64'(sat_out), 64'h800000);

    // back-to-back random stream checked every cycle by the model
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 9))
        0:       mode = 2'b00;
        1, 2:    mode = 2'b01;
        3:       mode = 2'b11;
        default: mode = 2'b10;
      endcase
      case ($urandom_range(0, 3))
        0:       begin op_a = 24'h800000; op_b = 24'h800000; end
        1:       begin op_a = 24'h7FFFFF; op_b = 24'h800000; end
        default: begin op_a = 24'($urandom); op_b = 24'($urandom); end
      endcase
    end
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule